// File: doc/BRIEF.md
# Chromatic Playback Speed Selector

This block turns detents of a quadrature rotary encoder into a playback speed for a pitch shifter. Each detent moves a step index by one semitone. The index ranges from 0 to 24, and 12 is the centre. The block looks the index up in a built-in equal-temperament table and writes the result to a 16-bit speed register in unsigned 8.8 fixed point. A value of 0x0100 plays back at the incoming rate. The full range covers one octave down (0x0080) to one octave up (0x0200).

The encoder pins are not examined on every clock. The block looks at them only on every 64th assertion of the per-sample tick, which thins out the pin activity it sees. The pins are assumed to be debounced before they reach the block. A detent is a falling level on pin A, seen at an examination. The level of pin B at that examination gives the direction. A latch stops a pin A that stays low from producing more than one detent.

Top module: `encoder_speed_select`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is `speed` = 0x0100, step index 12, tick count cleared and detent latch clear.
- R2: The pins are examined only on the clock edge where `tick` is high for the 64th time since reset or since the previous examination. Pin levels at any other edge have no effect on `speed`.
- R3: An examination with `enc_a` low and the detent latch clear counts as one detent and sets the latch. An examination with `enc_a` low and the latch set does nothing. An examination with `enc_a` high clears the latch and changes nothing else.
- R4: On a detent, `enc_b` = 0 raises the step index by one and `enc_b` = 1 lowers it by one.
- R5: The step index stays within 0 to 24. A detent that would move it past either end leaves the index and `speed` unchanged, but it still sets the detent latch.
- R6: `speed` always equals the table entry for the current index. Entry i is round(256 x 2^((i-12)/12)). Entry 0 is 0x0080, entry 12 is 0x0100 and entry 24 is 0x0200.
- R7: `speed` is written on the same clock edge as the index change that a detent causes. It holds its value on every edge without such a detent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle pulse per audio sample |
| enc_a | input | 1 | Encoder pin A, already debounced |
| enc_b | input | 1 | Encoder pin B, already debounced |
| speed | output | 16 | Playback increment, unsigned 8.8 |

## Verification
An examination happens on the clock edge that carries the 64th tick. A new `speed` is therefore visible right after that edge, with no further register in the path. The bench drives pins and ticks on falling edges, sends ticks in blocks that end on exactly that 64th tick, and samples `speed` on the falling edge that follows. To check R2, the bench sends 63 ticks and confirms that `speed` has not moved. It then sends one more tick and checks the change. Checks for ignored stimulus (pin activity with no ticks, a held-low pin A, a move past either end) all sample `speed` before the next examination can happen.

// File: rtl/speed_sel_pkg.sv
// Shared constants, types and the semitone speed table for the encoder
// speed selector. Table entries are round(256 * 2^((i-12)/12)).
package speed_sel_pkg;

    localparam int SEMITONES   = 12;
    localparam int IDX_MAX     = 2 * SEMITONES;
    localparam int IDX_W       = $clog2(IDX_MAX + 1);
    localparam int SPEED_W     = 16;

    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [SPEED_W-1:0] speed_t;

    // Direction decided at an examination of the pins
    typedef enum logic [1:0] {
        DIR_NONE = 2'b00,
        DIR_UP   = 2'b01,
        DIR_DOWN = 2'b10
    } dir_e;

    localparam idx_t IDX_CENTRE = idx_t'(SEMITONES);

    // Equal-temperament 8.8 increment for a step index
    function automatic speed_t semitone_speed(input idx_t i);
        speed_t s;
        case (i)
            idx_t'(0):  s = 16'h0080;
            idx_t'(1):  s = 16'h0088;
            idx_t'(2):  s = 16'h0090;
            idx_t'(3):  s = 16'h0098;
            idx_t'(4):  s = 16'h00A1;
            idx_t'(5):  s = 16'h00AB;
            idx_t'(6):  s = 16'h00B5;
            idx_t'(7):  s = 16'h00C0;
            idx_t'(8):  s = 16'h00CB;
            idx_t'(9):  s = 16'h00D7;
            idx_t'(10): s = 16'h00E4;
            idx_t'(11): s = 16'h00F2;
            idx_t'(12): s = 16'h0100;
            idx_t'(13): s = 16'h010F;
            idx_t'(14): s = 16'h011F;
            idx_t'(15): s = 16'h0130;
            idx_t'(16): s = 16'h0143;
            idx_t'(17): s = 16'h0156;
            idx_t'(18): s = 16'h016A;
            idx_t'(19): s = 16'h0180;
            idx_t'(20): s = 16'h0196;
            idx_t'(21): s = 16'h01AF;
            idx_t'(22): s = 16'h01C8;
            idx_t'(23): s = 16'h01E3;
            idx_t'(24): s = 16'h0200;
            default:    s = 16'h0100;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tick_divider.sv
// Tick divider: counts per-sample ticks and raises a one-cycle poll strobe
// on the tick that completes each group of POLL_TICKS.
// Assumes tick is a clean one-cycle pulse synchronous to clk.
module tick_divider #(
    parameter int POLL_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic poll
);
    localparam int CNT_W = (POLL_TICKS > 1) ? $clog2(POLL_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(POLL_TICKS - 1);

    logic [CNT_W-1:0] remain_q;

    // Strobe on the last tick of the group
    always_comb poll = tick && (remain_q == '0);

    // Count down remaining ticks, reload after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain_q <= CNT_TOP;
        else if (tick)
            remain_q <= (remain_q == '0) ? CNT_TOP : remain_q - 1'b1;
    end

endmodule

// File: rtl/detent_decoder.sv
// Detent decoder: at each poll, turns a falling level on pin A into one
// direction request, with pin B giving the sense. A latch holds off
// further requests until pin A is seen high at a poll.
// Assumes pins are debounced externally.
module detent_decoder
    import speed_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic poll,
    input  logic enc_a,
    input  logic enc_b,
    output dir_e dir
);
    logic latched_q;

    // Direction request for this poll
    always_comb begin
        dir = DIR_NONE;
        if (poll && !enc_a && !latched_q)
            dir = enc_b ? DIR_DOWN : DIR_UP;
    end

    // Latch follows pin A at each poll
    always_ff @(posedge clk) begin
        if (!rst_n)
            latched_q <= 1'b0;
        else if (poll)
            latched_q <= !enc_a;
    end

endmodule

// File: rtl/step_index.sv
// Step index: saturating counter between 0 and IDX_MAX, centred at reset.
// Reports the next value and whether it differs from the current one.
module step_index
    import speed_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  dir_e dir,
    output idx_t idx,
    output idx_t idx_next,
    output logic moved
);
    // Next index with end clamping
    always_comb begin
        idx_next = idx;
        unique case (dir)
            DIR_UP:   if (idx < idx_t'(IDX_MAX)) idx_next = idx + 1'b1;
            DIR_DOWN: if (idx > '0)              idx_next = idx - 1'b1;
            default:  idx_next = idx;
        endcase
        moved = (idx_next != idx);
    end

    // Index register
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= IDX_CENTRE;
        else
            idx <= idx_next;
    end

endmodule

// File: rtl/encoder_speed_select.sv
// Top: rotary encoder to chromatic playback speed. Polls the pins once per
// POLL_TICKS sample ticks, steps a semitone index and registers the 8.8
// speed from the table on the same edge the index moves.
module encoder_speed_select
    import speed_sel_pkg::*;
#(
    parameter int POLL_TICKS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        enc_a,
    input  logic        enc_b,
    output logic [15:0] speed
);
    logic poll_stb;
    dir_e step_dir;
    idx_t step_idx;
    idx_t step_idx_nx;
    logic step_moved;

    tick_divider #(.POLL_TICKS(POLL_TICKS)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .poll (poll_stb)
    );

    detent_decoder u_dec (
        .clk  (clk),
        .rst_n(rst_n),
        .poll (poll_stb),
        .enc_a(enc_a),
        .enc_b(enc_b),
        .dir  (step_dir)
    );

    step_index u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir     (step_dir),
        .idx     (step_idx),
        .idx_next(step_idx_nx),
        .moved   (step_moved)
    );

    // Speed register, written only when the index moves
    always_ff @(posedge clk) begin
        if (!rst_n)
            speed <= semitone_speed(IDX_CENTRE);
        else if (step_moved)
            speed <= semitone_speed(step_idx_nx);
    end

endmodule

// File: rtl/speed_sel_chk.sv
// Checker for encoder_speed_select, bound to every instance.
module speed_sel_chk
    import speed_sel_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        enc_a,
    input logic        enc_b,
    input logic        poll,
    input idx_t        step_idx,
    input logic [15:0] speed
);
    // R1
    reset_value_chk: assert property (@(posedge clk)
        !rst_n |=> (speed == 16'h0100 && step_idx == idx_t'(12)));

    // R2
    poll_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll |-> tick);

    // R3
    a_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll && enc_a) |=> $stable(speed));

    // R4
    up_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll && !enc_a && !enc_b) |=>
        (step_idx == $past(step_idx) || step_idx == $past(step_idx) + 1'b1));

    // R4
    down_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll && !enc_a && enc_b) |=>
        (step_idx == $past(step_idx) || step_idx == $past(step_idx) - 1'b1));

    // R5
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_idx <= idx_t'(IDX_MAX));

    // R6
    speed_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (speed >= 16'h0080 && speed <= 16'h0200));

    // R7
    no_poll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !poll |=> $stable(speed));

endmodule

bind encoder_speed_select speed_sel_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .enc_a   (enc_a),
    .enc_b   (enc_b),
    .poll    (poll_stb),
    .step_idx(step_idx),
    .speed   (speed)
);

// File: tb/tb_encoder_speed_select.sv
module tb_encoder_speed_select;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        enc_a = 1'b1;
    logic        enc_b = 1'b0;
    logic [15:0] speed;

    int checks = 0;
    int errors = 0;
    int m_idx = 12;
    bit m_latch = 1'b0;
    bit done = 1'b0;

    encoder_speed_select dut (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .enc_a(enc_a),
        .enc_b(enc_b),
        .speed(speed)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] exp_speed(input int i);
        real v;
        v = 256.0 * (2.0 ** ((real'(i) - 12.0) / 12.0));
        return 16'($rtoi(v + 0.5));
    endfunction

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (speed !== exp) begin
            errors++;
            $display("FAIL %s: speed=%h expected=%h", req, speed, exp);
        end
    endtask

    // n ticks, back to back, then sample on the following falling edge
    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
        @(negedge clk);
    endtask

    // Model of one examination
    task automatic model_poll(input bit a, input bit b);
        if (a) m_latch = 1'b0;
        else if (!m_latch) begin
            m_latch = 1'b1;
            if (!b && m_idx < 24) m_idx++;
            else if (b && m_idx > 0) m_idx--;
        end
    endtask

    task automatic poll(input bit a, input bit b, input string req);
        enc_a = a;
        enc_b = b;
        ticks(64);
        model_poll(a, b);
        check(req, exp_speed(m_idx));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset value
        check("R1", 16'h0100);

        // R2: 63 ticks with A low do nothing, the 64th examines
        enc_a = 1'b0; enc_b = 1'b0;
        ticks(63);
        check("R2", 16'h0100);
        ticks(1);
        model_poll(1'b0, 1'b0);
        check("R2", 16'h010F);

        // R3: held low, no second detent
        poll(1'b0, 1'b0, "R3");
        poll(1'b1, 1'b0, "R3");

        // R4/R6 upward sweep into the top end, R5 saturation
        for (int k = 0; k < 14; k++) begin
            poll(1'b1, 1'b0, "R3");
            poll(1'b0, 1'b0, "R4_R6");
        end
        check("R5", 16'h0200);

        // R4/R6 downward sweep past the bottom end
        for (int k = 0; k < 26; k++) begin
            poll(1'b1, 1'b1, "R3");
            poll(1'b0, 1'b1, "R4_R6");
        end
        check("R5", 16'h0080);

        // R5: the ignored move still sets the latch; a reversal must wait
        poll(1'b0, 1'b0, "R5");
        poll(1'b1, 1'b0, "R3");
        poll(1'b0, 1'b0, "R4");

        // R7: pin activity without ticks changes nothing
        for (int k = 0; k < 20; k++) begin
            enc_a = k[0]; enc_b = k[1];
            @(negedge clk);
        end
        check("R7", exp_speed(m_idx));

        // R2: pins toggled between examinations are not seen
        enc_a = 1'b1;
        ticks(32);
        enc_a = 1'b0;
        ticks(16);
        enc_a = 1'b1;
        ticks(16);
        model_poll(1'b1, 1'b0);
        check("R2", exp_speed(m_idx));

        // R1: reset mid-range returns to unity
        poll(1'b0, 1'b0, "R4");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_idx = 12; m_latch = 1'b0;
        @(negedge clk);
        check("R1", 16'h0100);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: done=0 expected=1");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule